// File: doc/BRIEF.md
# General-Purpose Pin Bank with Interrupt Detection

This block is a bank of up to 32 general-purpose pins behind a simple 32-bit register bus. Each pin is set up on its own as a plain input, a driven output, or an interrupt source. Pins that are outputs are driven from a held data register. Every incoming pin value passes through a synchroniser, and an optional per-pin filter can be placed after it.

An interrupt pin can be set to respond to a level or to an edge. A polarity bit chooses between high and low (or rising and falling), and a per-pin any-edge bit makes both transitions count. Edge events are latched until software clears them by writing ones. Level status follows the pin and is never latched. A per-pin enable is lowered through one register and raised through another. One combined request line is high while any enabled status bit is set.

The bus has no handshake. A write takes effect on the clock edge where the write strobe is high. Read data is a combinational function of the address.

Top module: `pio_bank`

## Requirements
- R1: After reset every control register, the output data and the enable register read 0. `pin_oe` is 0 and `irq` is 0.
- R2: Bit i of `pin_oe` is 1 only when the pin's mode bit (offset 0x00) is 0 and its direction bit (offset 0x04) is 1. Mode bit 1 means interrupt input. `pin_out` always equals the output data register (offset 0x08). That register keeps any value written while the pin is an input, so a value can be preloaded before the pin becomes an output.
- R3: The input data register (offset 0x0C) returns the pin values after a two-flop synchroniser. A pin change made before clock edge k becomes visible after edge k+1. Bits at or above NPIN always read 0.
- R4: In level mode (mode 1, sense bit at 0x24 = 0), the status bit at 0x10 equals the pin value XOR the polarity bit at 0x20. Polarity 0 means active high. The bit follows the pin and does not latch.
- R5: In edge mode (sense 1), polarity 0 latches status on a rising transition and polarity 1 latches it on a falling one.
- R6: When the any-edge bit (0x4C) of an edge-mode pin is 1, both transitions latch status, whatever its polarity bit.
- R7: Writing 1 to a bit of the clear register (0x14) clears that pin's latched edge status. Writing 0 leaves it unchanged.
- R8: The enable register (0x18) reads 1 for each unmasked pin. Writing 0 to a bit masks that pin and writing 1 leaves it unchanged. Writing 1 to a bit at 0x1C unmasks that pin and writing 0 leaves it unchanged.
- R9: `irq` is 1 exactly while some status bit is set whose enable bit is 1.
- R10: When a pin's filter bit (0x28) is 1, a synchronised change is accepted only after it has held for two consecutive samples. A one-cycle pulse is then ignored.
- R11: Registers are decoded at the offsets listed above on the full address. Unlisted addresses read 0, and writes to them are ignored.
- R12: The input data and status registers are read-only. Writes to them change neither.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | NPIN | Pin values from the pads |
| pin_out | output | NPIN | Output drive values |
| pin_oe | output | NPIN | Output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the bank with NPIN = 12 and the default two synchroniser stages. With a partial bank it can show that bits above the pin count read 0 even after an all-ones write. Twelve pins leave room to run level pins of both polarities, rising, falling and any-edge pins, and a filtered pin next to an unfiltered one, all at the same time. With the default depth, the two-sample latency of the input path can be checked on exact cycles.

// File: rtl/pio_bank_pkg.sv
package pio_bank_pkg;
   localparam int BUS_W    = 32;
   localparam int MAX_PINS = 32;
   localparam int MIN_ADDR = 8;

   // register byte offsets, decoded by the bus and relied on by software
   localparam logic [7:0] OFF_MODE   = 8'h00;
   localparam logic [7:0] OFF_DIR    = 8'h04;
   localparam logic [7:0] OFF_DOUT   = 8'h08;
   localparam logic [7:0] OFF_DIN    = 8'h0C;
   localparam logic [7:0] OFF_STAT   = 8'h10;
   localparam logic [7:0] OFF_ACK    = 8'h14;
   localparam logic [7:0] OFF_EN     = 8'h18;
   localparam logic [7:0] OFF_UNMASK = 8'h1C;
   localparam logic [7:0] OFF_POL    = 8'h20;
   localparam logic [7:0] OFF_SENSE  = 8'h24;
   localparam logic [7:0] OFF_FILT   = 8'h28;
   localparam logic [7:0] OFF_ANY    = 8'h4C;
endpackage

// File: rtl/pio_bank_sync.sv
module pio_bank_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pio_bank_detect.sv
module pio_bank_detect #(
   parameter int NPIN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] sync_in,
   input  logic [NPIN-1:0] mode,
   input  logic [NPIN-1:0] pol,
   input  logic [NPIN-1:0] sense,
   input  logic [NPIN-1:0] any_e,
   input  logic [NPIN-1:0] filt,
   input  logic [NPIN-1:0] ack,
   output logic [NPIN-1:0] val,
   output logic [NPIN-1:0] hit,
   output logic [NPIN-1:0] stat
);
   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      logic s_prev, f_q, eff, e_prev, rise, fall, edge_md, latch;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_prev <= 1'b0;
            f_q    <= 1'b0;
            e_prev <= 1'b0;
         end else begin
            s_prev <= sync_in[i];
            if (!filt[i] || (sync_in[i] == s_prev)) f_q <= sync_in[i];
            e_prev <= eff;
         end
      end

      assign eff     = filt[i] ? f_q : sync_in[i];
      assign rise    = eff & ~e_prev;
      assign fall    = ~eff & e_prev;
      assign edge_md = mode[i] & sense[i];
      assign hit[i]  = edge_md & (any_e[i] ? (rise | fall) : (pol[i] ? fall : rise));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        latch <= 1'b0;
         else if (!edge_md) latch <= 1'b0;
         else if (hit[i])   latch <= 1'b1;
         else if (ack[i])   latch <= 1'b0;
      end

      assign val[i]  = eff;
      assign stat[i] = mode[i] & (sense[i] ? latch : (eff ^ pol[i]));
   end
endmodule

// File: rtl/pio_bank_regs.sv
module pio_bank_regs
   import pio_bank_pkg::*;
#(
   parameter int NPIN   = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic [NPIN-1:0]   pin_val,
   input  logic [NPIN-1:0]   stat,
   output logic [NPIN-1:0]   mode_q,
   output logic [NPIN-1:0]   dir_q,
   output logic [NPIN-1:0]   dout_q,
   output logic [NPIN-1:0]   pol_q,
   output logic [NPIN-1:0]   sense_q,
   output logic [NPIN-1:0]   filt_q,
   output logic [NPIN-1:0]   any_q,
   output logic [NPIN-1:0]   en_q,
   output logic [NPIN-1:0]   ack,
   output logic [BUS_W-1:0]  rdata
);
   localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(OFF_MODE);
   localparam logic [ADDR_W-1:0] A_DIR    = ADDR_W'(OFF_DIR);
   localparam logic [ADDR_W-1:0] A_DOUT   = ADDR_W'(OFF_DOUT);
   localparam logic [ADDR_W-1:0] A_DIN    = ADDR_W'(OFF_DIN);
   localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFF_ACK);
   localparam logic [ADDR_W-1:0] A_EN     = ADDR_W'(OFF_EN);
   localparam logic [ADDR_W-1:0] A_UNMASK = ADDR_W'(OFF_UNMASK);
   localparam logic [ADDR_W-1:0] A_POL    = ADDR_W'(OFF_POL);
   localparam logic [ADDR_W-1:0] A_SENSE  = ADDR_W'(OFF_SENSE);
   localparam logic [ADDR_W-1:0] A_FILT   = ADDR_W'(OFF_FILT);
   localparam logic [ADDR_W-1:0] A_ANY    = ADDR_W'(OFF_ANY);

   logic [NPIN-1:0] wd;
   logic [NPIN-1:0] rsel;

   assign wd  = wdata[NPIN-1:0];
   assign ack = (wr_en && (addr == A_ACK)) ? wd : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         dir_q   <= '0;
         dout_q  <= '0;
         pol_q   <= '0;
         sense_q <= '0;
         filt_q  <= '0;
         any_q   <= '0;
         en_q    <= '0;
      end else if (wr_en) begin
         case (addr)
            A_MODE:   mode_q  <= wd;
            A_DIR:    dir_q   <= wd;
            A_DOUT:   dout_q  <= wd;
            A_POL:    pol_q   <= wd;
            A_SENSE:  sense_q <= wd;
            A_FILT:   filt_q  <= wd;
            A_ANY:    any_q   <= wd;
            A_EN:     en_q    <= en_q & wd;
            A_UNMASK: en_q    <= en_q | wd;
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (addr)
         A_MODE:  rsel = mode_q;
         A_DIR:   rsel = dir_q;
         A_DOUT:  rsel = dout_q;
         A_DIN:   rsel = pin_val;
         A_STAT:  rsel = stat;
         A_EN:    rsel = en_q;
         A_POL:   rsel = pol_q;
         A_SENSE: rsel = sense_q;
         A_FILT:  rsel = filt_q;
         A_ANY:   rsel = any_q;
         default: rsel = '0;
      endcase
      rdata            = '0;
      rdata[NPIN-1:0]  = rsel;
   end
endmodule

// File: rtl/pio_bank.sv
module pio_bank
   import pio_bank_pkg::*;
#(
   parameter int NPIN        = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [NPIN-1:0]   pin_in,
   output logic [NPIN-1:0]   pin_out,
   output logic [NPIN-1:0]   pin_oe,
   output logic              irq
);
   if (NPIN < 1 || NPIN > MAX_PINS) begin : g_bad_npin
      $error("pio_bank: NPIN must lie in 1..32");
   end
   if (ADDR_W < MIN_ADDR) begin : g_bad_addr
      $error("pio_bank: ADDR_W must be at least 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pio_bank: SYNC_STAGES must be at least 2");
   end

   logic [NPIN-1:0] sync_q, pin_val, stat, hit, ack;
   logic [NPIN-1:0] mode_q, dir_q, dout_q, pol_q, sense_q, filt_q, any_q, en_q;

   pio_bank_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst_n(rst_n),
      .d   (pin_in),
      .q   (sync_q)
   );

   pio_bank_detect #(.NPIN(NPIN)) u_detect (
      .clk    (clk),
      .rst_n  (rst_n),
      .sync_in(sync_q),
      .mode   (mode_q),
      .pol    (pol_q),
      .sense  (sense_q),
      .any_e  (any_q),
      .filt   (filt_q),
      .ack    (ack),
      .val    (pin_val),
      .hit    (hit),
      .stat   (stat)
   );

   pio_bank_regs #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bus_wr),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .pin_val(pin_val),
      .stat   (stat),
      .mode_q (mode_q),
      .dir_q  (dir_q),
      .dout_q (dout_q),
      .pol_q  (pol_q),
      .sense_q(sense_q),
      .filt_q (filt_q),
      .any_q  (any_q),
      .en_q   (en_q),
      .ack    (ack),
      .rdata  (bus_rdata)
   );

   assign pin_out = dout_q;
   assign pin_oe  = ~mode_q & dir_q;
   assign irq     = |(stat & en_q);
endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk
   import pio_bank_pkg::*;
#(
   parameter int NPIN   = 32,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic [NPIN-1:0]   pin_out,
   input logic [NPIN-1:0]   mode,
   input logic [NPIN-1:0]   sense,
   input logic [NPIN-1:0]   pol,
   input logic [NPIN-1:0]   filt,
   input logic [NPIN-1:0]   en,
   input logic [NPIN-1:0]   stat,
   input logic [NPIN-1:0]   hit,
   input logic [NPIN-1:0]   sync_q
);
   logic [NPIN-1:0] wd;
   logic [NPIN-1:0] edge_st;
   assign wd      = bus_wdata[NPIN-1:0];
   assign edge_st = stat & mode & sense;

   // R2: output data only moves on a write to its own offset
   p_dout_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == ADDR_W'(OFF_DOUT)) |=> $stable(pin_out));

   // R4: unfiltered level status mirrors the synchroniser output
   p_level_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode & ~sense & ~filt & (stat ^ sync_q ^ pol)) == '0));

   // R5: an edge status bit only rises after a detected transition
   p_edge_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((edge_st & ~$past(edge_st) & ~$past(hit)) == '0));

   // R7: clearing without a coincident event leaves the bit low
   p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFF_ACK)) |=> ((edge_st & $past(wd & ~hit)) == '0));

   // R8: zero bits written to the enable register mask those pins
   p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFF_EN)) |=> ((en & ~$past(wd)) == '0));

   // R8: one bits written to the unmask register enable those pins
   p_unmask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFF_UNMASK)) |=> ((en & $past(wd)) == $past(wd)));
endmodule

bind pio_bank pio_bank_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .pin_out  (pin_out),
   .mode     (mode_q),
   .sense    (sense_q),
   .pol      (pol_q),
   .filt     (filt_q),
   .en       (en_q),
   .stat     (stat),
   .hit      (hit),
   .sync_q   (sync_q)
);

// File: tb/pio_bank_tb.sv
module pio_bank_tb;
   localparam int NP = 12;
   localparam int SRC_RD = 0, SRC_OUT = 1, SRC_OE = 2, SRC_IRQ = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [7:0]      bus_addr = '0;
   logic            bus_wr = 1'b0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [NP-1:0]   pin_in = '0;
   logic [NP-1:0]   pin_out, pin_oe;
   logic            irq;

   typedef struct { int src; logic [31:0] exp; string tag; } item_t;
   item_t q[$];
   event  ev_sample;
   int    n_chk = 0, n_fail = 0;
   bit    done = 0;

   always #2 clk = ~clk;

   pio_bank #(.NPIN(NP), .ADDR_W(8), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   // monitor: pops expected items and compares with the live outputs
   initial begin
      forever begin
         @(ev_sample);
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.src)
               SRC_RD:  act = bus_rdata;
               SRC_OUT: act = 32'(pin_out);
               SRC_OE:  act = 32'(pin_oe);
               default: act = 32'(irq);
            endcase
            n_chk++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      bus_addr = a;
      #1;
      it.src = SRC_RD; it.exp = e; it.tag = tag;
      q.push_back(it);
      ->ev_sample;
   endtask

   task automatic exp_sig(input int src, input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      #1;
      it.src = src; it.exp = e; it.tag = tag;
      q.push_back(it);
      ->ev_sample;
   endtask

   task automatic pins(input logic [NP-1:0] v);
      @(negedge clk);
      pin_in = v;
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      #(4 * 50000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      wait_clk(3);
      @(negedge clk) rst_n = 1'b1;

      // reset state
      exp_rd(8'h00, 32'h0, "R1 mode after reset");
      exp_rd(8'h04, 32'h0, "R1 direction after reset");
      exp_rd(8'h08, 32'h0, "R1 output data after reset");
      exp_rd(8'h18, 32'h0, "R1 enable after reset");
      exp_rd(8'h10, 32'h0, "R1 status after reset");
      exp_sig(SRC_OE, 32'h0, "R1 oe after reset");
      exp_sig(SRC_IRQ, 32'h0, "R1 irq after reset");

      // output preload and direction
      wr(8'h08, 32'h0A5);
      exp_sig(SRC_OE, 32'h0, "R2 oe while input");
      exp_sig(SRC_OUT, 32'h0A5, "R2 preload on pin_out");
      wr(8'h04, 32'h0FF);
      exp_sig(SRC_OE, 32'h0FF, "R2 oe after direction");
      wr(8'h00, 32'h00F);
      exp_sig(SRC_OE, 32'h0F0, "R2 interrupt pins not driven");
      exp_sig(SRC_OUT, 32'h0A5, "R2 output data held");
      wr(8'h00, 32'h0);
      wr(8'h04, 32'h0);
      wr(8'h08, 32'hFFFF_FFFF);
      exp_rd(8'h08, 32'h0000_0FFF, "R3 bits above NPIN read zero");
      wr(8'h08, 32'h0);
      wr(8'h40, 32'hFFFF_FFFF);
      exp_rd(8'h40, 32'h0, "R11 unlisted address reads zero");
      exp_rd(8'h00, 32'h0, "R11 unlisted write ignored");

      // synchroniser latency
      pins(12'h123);
      exp_rd(8'h0C, 32'h0, "R3 input not yet visible");
      exp_rd(8'h0C, 32'h123, "R3 input after two stages");
      wr(8'h0C, 32'h0);
      exp_rd(8'h0C, 32'h123, "R12 input register read-only");
      pins(12'h000);
      wait_clk(3);

      // level sensing
      wr(8'h20, 32'h0);
      wr(8'h24, 32'h0);
      wr(8'h00, 32'h001);
      wr(8'h1C, 32'h001);
      exp_rd(8'h10, 32'h0, "R4 level high idle");
      pins(12'h001);
      wait_clk(3);
      exp_rd(8'h10, 32'h001, "R4 level high active");
      exp_sig(SRC_IRQ, 32'h1, "R9 irq from enabled level");
      pins(12'h000);
      wait_clk(3);
      exp_rd(8'h10, 32'h0, "R4 level status not latched");
      exp_sig(SRC_IRQ, 32'h0, "R9 irq drops with level");
      wr(8'h20, 32'h002);
      wr(8'h00, 32'h003);
      exp_rd(8'h10, 32'h002, "R4 active-low pin");
      exp_sig(SRC_IRQ, 32'h0, "R9 masked status no irq");
      wr(8'h1C, 32'h002);
      exp_sig(SRC_IRQ, 32'h1, "R9 irq after unmask");
      wr(8'h18, 32'hFFFF_FFFD);
      exp_rd(8'h18, 32'h001, "R8 write zero masks");
      exp_sig(SRC_IRQ, 32'h0, "R9 irq after mask");
      wr(8'h18, 32'hFFFF_FFFF);
      exp_rd(8'h18, 32'h001, "R8 ones to mask no effect");
      wr(8'h1C, 32'h0);
      exp_rd(8'h18, 32'h001, "R8 zeros to unmask no effect");
      wr(8'h00, 32'h0);
      wr(8'h20, 32'h0);

      // edge sensing
      wr(8'h24, 32'h0F0);
      wr(8'h20, 32'h020);
      wr(8'h00, 32'h0F0);
      wr(8'h1C, 32'hFFF);
      exp_rd(8'h10, 32'h0, "R5 edge idle");
      pins(12'h030);
      wait_clk(4);
      exp_rd(8'h10, 32'h010, "R5 rising latched falling not");
      exp_sig(SRC_IRQ, 32'h1, "R9 irq on edge");
      pins(12'h000);
      wait_clk(4);
      exp_rd(8'h10, 32'h030, "R5 falling latched rising held");

      // clearing
      wr(8'h14, 32'h020);
      exp_rd(8'h10, 32'h010, "R7 clear one pin");
      wr(8'h14, 32'h0);
      exp_rd(8'h10, 32'h010, "R7 zero clear no effect");
      wr(8'h14, 32'h010);
      exp_rd(8'h10, 32'h0, "R7 clear last pin");
      exp_sig(SRC_IRQ, 32'h0, "R9 irq after clear");
      pins(12'h010);
      wait_clk(4);
      wr(8'h10, 32'h0);
      exp_rd(8'h10, 32'h010, "R12 status register read-only");
      wr(8'h14, 32'h010);
      pins(12'h000);
      wait_clk(3);

      // any-edge
      wr(8'h4C, 32'h040);
      wr(8'h20, 32'h060);
      pins(12'h040);
      wait_clk(4);
      exp_rd(8'h10, 32'h040, "R6 any-edge rising despite polarity");
      wr(8'h14, 32'h040);
      exp_rd(8'h10, 32'h0, "R7 clear any-edge");
      pins(12'h000);
      wait_clk(4);
      exp_rd(8'h10, 32'h040, "R6 any-edge falling");
      wr(8'h14, 32'h040);

      // filter
      wr(8'h28, 32'h080);
      pins(12'h080);
      pins(12'h000);
      wait_clk(5);
      exp_rd(8'h10, 32'h0, "R10 short pulse filtered");
      pins(12'h010);
      pins(12'h000);
      wait_clk(5);
      exp_rd(8'h10, 32'h010, "R10 short pulse seen unfiltered");
      wr(8'h14, 32'h010);
      pins(12'h080);
      wait_clk(6);
      exp_rd(8'h10, 32'h080, "R10 held change accepted");
      exp_rd(8'h0C, 32'h080, "R10 filtered input value");

      wait_clk(2);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule